// File: doc/BRIEF.md
# Best-Ask Book Updater

This block keeps a compact book of resting sell orders for a single instrument and watches the lowest ask. Decoded order records arrive one at a time on a valid/ready stream. Each record carries an action, an order identifier, an instrument identifier, a side, a price and a quantity. A flag marks the last record of a packet. Every record that belongs to the packet changes the book. Records for another instrument or for the buy side are taken off the stream and dropped.

Once the last record of a packet has been taken, the block stops accepting input. It sweeps the order table, one entry per cycle, to find the lowest live ask. It then compares that value with the best price it held before the packet. If the two differ, it raises a one-cycle buy trigger carrying the new price. An empty book reads as an all-ones price.

The block sits between a market-data decoder and a buy-message formatter. It settles at most one decision per packet, however many records the packet holds.

Top module: `ask_book_top`

## Requirements
- R1: After reset, `rec_ready_o` is 1, `trig_valid_o` is 0, `best_price_o` is all ones, and `overflow_o` and `error_o` are 0.
- R2: The record action code on `rec_act_i` is 0 for add, 1 for modify (replace price and quantity) and 2 for delete. Code 3 leaves the book and the flags unchanged.
- R3: Only records whose `rec_inst_i` equals parameter `INST_ID` and whose `rec_side_i` is 1 (sell) change the book. All other records are accepted and have no effect on the book, the flags or the trigger.
- R4: Every record of a packet is applied before the single per-packet decision. `rec_ready_o` falls on the cycle after the record with `rec_last_i` = 1 is accepted, and stays low until the decision is made.
- R5: The best price is the lowest price among table entries that are valid and hold a nonzero quantity.
- R6: At the decision, `trig_valid_o` pulses for exactly one cycle with `trig_price_o` equal to the new best price, if and only if that price differs from the `best_price_o` held before the packet. The pulse comes in the same cycle that `rec_ready_o` returns to 1, and `best_price_o` takes the new value at that point.
- R7: With no live sell order, the best price is all ones. A change to or from this value raises a trigger like any other change.
- R8: An add to an identifier that is already valid is ignored and sets the sticky `overflow_o`.
- R9: A modify or delete of an identifier that is not valid is ignored and sets the sticky `error_o`.
- R10: The decision is made no more than 2^ID_W + 2 cycles after the last record is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record valid |
| rec_ready_o | output | 1 | Block can accept a record |
| rec_last_i | input | 1 | Record is the last of its packet |
| rec_act_i | input | 2 | Action: 0 add, 1 modify, 2 delete |
| rec_oid_i | input | ID_W | Order identifier, used as the table index |
| rec_inst_i | input | INST_W | Instrument identifier |
| rec_side_i | input | 1 | 1 sell, 0 buy |
| rec_price_i | input | PRICE_W | Order price |
| rec_qty_i | input | QTY_W | Order quantity in lots |
| trig_valid_o | output | 1 | One-cycle buy trigger |
| trig_price_o | output | PRICE_W | Price carried by the trigger |
| best_price_o | output | PRICE_W | Best ask held after the last decision |
| overflow_o | output | 1 | Sticky: add hit an occupied identifier |
| error_o | output | 1 | Sticky: modify or delete hit an unknown identifier |

## Verification
The bench fills the whole table with arithmetically spread prices and checks the minimum. It then deletes the orders one packet at a time, in two different orders. Because the minimum sometimes moves and sometimes stays, this separates a correct change test from one that fires on every packet.

A 128-record packet moves one order's price through lower values before settling on its final price. This shows whether the decision waits for the whole packet.

Further packets cover several other cases:
- foreign-instrument and buy-side records;
- a zero quantity;
- unknown and duplicate identifiers;
- emptying the book, which makes the best price all ones.

These show whether the filter, the liveness rule and the sticky flags each act alone.

// File: rtl/ask_book_pkg.sv
package ask_book_pkg;
  typedef enum logic [1:0] {
    ACT_ADD = 2'd0,
    ACT_MOD = 2'd1,
    ACT_DEL = 2'd2,
    ACT_NOP = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    ST_RX     = 2'd0,
    ST_SCAN   = 2'd1,
    ST_DECIDE = 2'd2
  } fsm_e;
endpackage

// File: rtl/ask_book_table.sv
module ask_book_table
  import ask_book_pkg::*;
#(
  parameter int ID_W    = 6,
  parameter int PRICE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  act_e               wr_act_i,
  input  logic [ID_W-1:0]    wr_id_i,
  input  logic [PRICE_W-1:0] wr_price_i,
  input  logic               wr_live_i,
  input  logic [ID_W-1:0]    rd_id_i,
  output logic               rd_live_o,
  output logic [PRICE_W-1:0] rd_price_o,
  output logic               ovf_set_o,
  output logic               err_set_o
);
  localparam int DEPTH = 1 << ID_W;

  logic               vld_q  [DEPTH];
  logic               live_q [DEPTH];
  logic [PRICE_W-1:0] price_q[DEPTH];
  logic               hit;

  assign hit        = vld_q[wr_id_i];
  assign ovf_set_o  = wr_en_i && (wr_act_i == ACT_ADD) && hit;
  assign err_set_o  = wr_en_i && (wr_act_i == ACT_MOD || wr_act_i == ACT_DEL) && !hit;
  assign rd_live_o  = vld_q[rd_id_i] && live_q[rd_id_i];
  assign rd_price_o = price_q[rd_id_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i]   <= 1'b0;
        live_q[i]  <= 1'b0;
        price_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      unique case (wr_act_i)
        ACT_ADD: if (!hit) begin
          vld_q[wr_id_i]   <= 1'b1;
          live_q[wr_id_i]  <= wr_live_i;
          price_q[wr_id_i] <= wr_price_i;
        end
        ACT_MOD: if (hit) begin
          live_q[wr_id_i]  <= wr_live_i;
          price_q[wr_id_i] <= wr_price_i;
        end
        ACT_DEL: if (hit) begin
          vld_q[wr_id_i]  <= 1'b0;
          live_q[wr_id_i] <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ask_book_min.sv
module ask_book_min #(
  parameter int PRICE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic               live_i,
  input  logic [PRICE_W-1:0] price_i,
  output logic [PRICE_W-1:0] min_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 min_o <= '1;
    else if (clr_i)                              min_o <= '1;
    else if (en_i && live_i && price_i < min_o)  min_o <= price_i;
  end
endmodule

// File: rtl/ask_book_top.sv
module ask_book_top
  import ask_book_pkg::*;
#(
  parameter int ID_W    = 6,
  parameter int INST_W  = 8,
  parameter int PRICE_W = 16,
  parameter int QTY_W   = 16,
  parameter logic [INST_W-1:0] INST_ID = 8'd5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rec_valid_i,
  output logic               rec_ready_o,
  input  logic               rec_last_i,
  input  logic [1:0]         rec_act_i,
  input  logic [ID_W-1:0]    rec_oid_i,
  input  logic [INST_W-1:0]  rec_inst_i,
  input  logic               rec_side_i,
  input  logic [PRICE_W-1:0] rec_price_i,
  input  logic [QTY_W-1:0]   rec_qty_i,
  output logic               trig_valid_o,
  output logic [PRICE_W-1:0] trig_price_o,
  output logic [PRICE_W-1:0] best_price_o,
  output logic               overflow_o,
  output logic               error_o
);
  localparam int DEPTH = 1 << ID_W;
  localparam logic [ID_W-1:0] LAST_IDX = ID_W'(DEPTH - 1);

  fsm_e               state_q;
  logic [ID_W-1:0]    idx_q;
  logic               accept, wr_en, start;
  logic               rd_live, ovf_set, err_set;
  logic [PRICE_W-1:0] rd_price, min_price;

  assign rec_ready_o = (state_q == ST_RX);
  assign accept      = rec_valid_i && rec_ready_o;
  assign wr_en       = accept && (rec_inst_i == INST_ID) && rec_side_i;
  assign start       = accept && rec_last_i;

  ask_book_table #(.ID_W(ID_W), .PRICE_W(PRICE_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_act_i   (act_e'(rec_act_i)),
    .wr_id_i    (rec_oid_i),
    .wr_price_i (rec_price_i),
    .wr_live_i  (rec_qty_i != '0),
    .rd_id_i    (idx_q),
    .rd_live_o  (rd_live),
    .rd_price_o (rd_price),
    .ovf_set_o  (ovf_set),
    .err_set_o  (err_set)
  );

  ask_book_min #(.PRICE_W(PRICE_W)) u_min (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .en_i    (state_q == ST_SCAN),
    .live_i  (rd_live),
    .price_i (rd_price),
    .min_o   (min_price)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RX;
      idx_q        <= '0;
      trig_valid_o <= 1'b0;
      trig_price_o <= '0;
      best_price_o <= '1;
      overflow_o   <= 1'b0;
      error_o      <= 1'b0;
    end else begin
      trig_valid_o <= 1'b0;
      if (ovf_set) overflow_o <= 1'b1;
      if (err_set) error_o    <= 1'b1;
      unique case (state_q)
        ST_RX: if (start) begin
          state_q <= ST_SCAN;
          idx_q   <= '0;
        end
        ST_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          state_q <= ST_RX;
          if (min_price != best_price_o) begin
            trig_valid_o <= 1'b1;
            trig_price_o <= min_price;
            best_price_o <= min_price;
          end
        end
        default: state_q <= ST_RX;
      endcase
    end
  end
endmodule

// File: rtl/ask_book_chk.sv
module ask_book_chk #(
  parameter int ID_W    = 6,
  parameter int PRICE_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rec_valid_i,
  input logic               rec_ready_o,
  input logic               rec_last_i,
  input logic               trig_valid_o,
  input logic [PRICE_W-1:0] trig_price_o,
  input logic [PRICE_W-1:0] best_price_o,
  input logic               overflow_o,
  input logic               error_o
);
  localparam int DEPTH = 1 << ID_W;
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_cnt <= 0;
    else if (rec_ready_o) busy_cnt <= 0;
    else                  busy_cnt <= busy_cnt + 1;
  end

  // R6
  trig_with_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_valid_o |-> rec_ready_o && $rose(rec_ready_o));
  // R6
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_valid_o |=> !trig_valid_o);
  // R6
  trig_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_valid_o |-> (trig_price_o == best_price_o) && (trig_price_o != $past(best_price_o)));
  // R6
  best_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_valid_o |-> $stable(best_price_o));
  // R4
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rec_ready_o) |-> $past(rec_valid_i && rec_last_i));
  // R8
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R9
  error_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);
  // R10
  decide_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= DEPTH + 2);
endmodule

bind ask_book_top ask_book_chk #(.ID_W(ID_W), .PRICE_W(PRICE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rec_valid_i  (rec_valid_i),
  .rec_ready_o  (rec_ready_o),
  .rec_last_i   (rec_last_i),
  .trig_valid_o (trig_valid_o),
  .trig_price_o (trig_price_o),
  .best_price_o (best_price_o),
  .overflow_o   (overflow_o),
  .error_o      (error_o)
);

// File: tb/tb_ask_book_top.sv
module tb_ask_book_top;
  localparam int ID_W = 6, INST_W = 8, PRICE_W = 16, QTY_W = 16;
  localparam int DEPTH = 1 << ID_W;
  localparam logic [INST_W-1:0] INST = 8'd5;
  localparam logic [PRICE_W-1:0] SENT = '1;

  logic clk = 0, rst_n = 0;
  logic rec_valid = 0, rec_last = 0, rec_side = 0;
  logic [1:0] rec_act = 0;
  logic [ID_W-1:0] rec_oid = 0;
  logic [INST_W-1:0] rec_inst = 0;
  logic [PRICE_W-1:0] rec_price = 0;
  logic [QTY_W-1:0] rec_qty = 0;
  logic rec_ready, trig_valid, overflow, error;
  logic [PRICE_W-1:0] trig_price, best_price;

  int total = 0, bad = 0;
  logic m_vld[DEPTH], m_live[DEPTH];
  logic [PRICE_W-1:0] m_price[DEPTH];
  logic [PRICE_W-1:0] m_best = SENT;
  logic m_ovf = 0, m_err = 0;

  always #4 clk = ~clk;

  ask_book_top #(.ID_W(ID_W), .INST_W(INST_W), .PRICE_W(PRICE_W), .QTY_W(QTY_W),
                 .INST_ID(INST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rec_valid_i(rec_valid), .rec_ready_o(rec_ready),
    .rec_last_i(rec_last), .rec_act_i(rec_act), .rec_oid_i(rec_oid), .rec_inst_i(rec_inst),
    .rec_side_i(rec_side), .rec_price_i(rec_price), .rec_qty_i(rec_qty),
    .trig_valid_o(trig_valid), .trig_price_o(trig_price), .best_price_o(best_price),
    .overflow_o(overflow), .error_o(error));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PRICE_W-1:0] model_min();
    logic [PRICE_W-1:0] m = SENT;
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_live[i] && m_price[i] < m) m = m_price[i];
    return m;
  endfunction

  task automatic finish_pkt(input string req);
    logic [PRICE_W-1:0] exp_min, got_price;
    int pulses = 0;
    bit exp_trig;
    exp_min  = model_min();
    exp_trig = (exp_min != m_best);
    got_price = '0;
    @(negedge clk);
    chk(rec_ready == 0, "R4 ready low after last", rec_ready, 0);
    for (int c = 0; c < DEPTH + 4; c++) begin
      if (trig_valid) begin pulses++; got_price = trig_price; end
      if (rec_ready) break;
      @(negedge clk);
    end
    chk(rec_ready == 1, "R10 decision in time", rec_ready, 1);
    chk(pulses == (exp_trig ? 1 : 0), {"R6 trigger count ", req}, pulses, exp_trig);
    if (exp_trig) chk(got_price == exp_min, {"R5 trigger price ", req}, got_price, exp_min);
    if (exp_trig) m_best = exp_min;
    chk(best_price == m_best, {"R5 best price ", req}, best_price, m_best);
    chk(overflow == m_ovf, {"R8 overflow ", req}, overflow, m_ovf);
    chk(error == m_err, {"R9 error ", req}, error, m_err);
    @(negedge clk);
    chk(trig_valid == 0, "R6 single-cycle pulse", trig_valid, 0);
  endtask

  task automatic send(input logic [1:0] act, input int id, input logic [INST_W-1:0] inst,
                      input logic side, input int price, input int qty, input bit last,
                      input string req);
    while (!rec_ready) @(negedge clk);
    rec_valid = 1; rec_act = act; rec_oid = ID_W'(id); rec_inst = inst; rec_side = side;
    rec_price = PRICE_W'(price); rec_qty = QTY_W'(qty); rec_last = last;
    @(posedge clk);
    #1 rec_valid = 0; rec_last = 0;
    if (inst == INST && side) begin
      case (act)
        2'd0: if (m_vld[id]) m_ovf = 1;
              else begin m_vld[id] = 1; m_live[id] = (qty != 0); m_price[id] = PRICE_W'(price); end
        2'd1: if (!m_vld[id]) m_err = 1;
              else begin m_live[id] = (qty != 0); m_price[id] = PRICE_W'(price); end
        2'd2: if (!m_vld[id]) m_err = 1; else begin m_vld[id] = 0; m_live[id] = 0; end
        default: ;
      endcase
    end
    if (last) finish_pkt(req);
    else @(negedge clk);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_live[i] = 0; m_price[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rec_ready == 1, "R1 ready", rec_ready, 1);
    chk(trig_valid == 0, "R1 trig", trig_valid, 0);
    chk(best_price == SENT, "R1 best", best_price, SENT);
    chk(!overflow && !error, "R1 flags", {overflow, error}, 0);

    // R2 add, R7 leave sentinel
    send(2'd0, 3, INST, 1, 100, 10, 1, "R7 first add");
    send(2'd0, 4, INST, 1, 200, 10, 1, "R6 higher add no trig");
    send(2'd0, 5, INST, 1, 300, 5, 0, "");
    send(2'd0, 6, INST, 1, 50, 5, 1, "R4 lower in multi-record packet");
    // R3 foreign instrument and buy side ignored
    send(2'd0, 7, INST + 1, 1, 10, 5, 0, "");
    send(2'd0, 8, INST, 0, 10, 5, 0, "");
    send(2'd2, 6, INST + 1, 1, 0, 0, 1, "R3 ignored records");
    // R2 code 3 no effect
    send(2'd3, 6, INST, 1, 1, 1, 1, "R2 nop code");
    // R5 zero qty not live
    send(2'd1, 6, INST, 1, 50, 0, 1, "R5 zero qty modify");
    send(2'd1, 6, INST, 1, 40, 7, 1, "R2 modify price");
    // R9 unknown ids
    send(2'd1, 40, INST, 1, 1, 1, 1, "R9 modify unknown");
    send(2'd2, 41, INST, 1, 0, 0, 1, "R9 delete unknown");
    // R8 duplicate add
    send(2'd0, 3, INST, 1, 1, 1, 1, "R8 duplicate add");
    // R4 128-record packet, intermediate lows must not leak
    for (int k = 0; k < 128; k++)
      send(2'd1, 4, INST, 1, (k == 127) ? 35 : 5 + (k % 20), 3, k == 127, "R4 long packet");
    // R7 empty the book
    send(2'd2, 3, INST, 1, 0, 0, 0, "");
    send(2'd2, 4, INST, 1, 0, 0, 0, "");
    send(2'd2, 5, INST, 1, 0, 0, 0, "");
    send(2'd2, 6, INST, 1, 0, 0, 1, "R7 empty to sentinel");
    // R5 sweep: fill whole table, then drain one per packet
    for (int i = 0; i < DEPTH; i++)
      send(2'd0, i, INST, 1, ((i * 37) % 101) + 10, i % 3 + 1, i == DEPTH - 1, "R5 full table");
    for (int i = 0; i < DEPTH; i++)
      send(2'd2, (i * 5) % DEPTH, INST, 1, 0, 0, 1, "R5 drain order A");
    for (int i = 0; i < DEPTH; i++)
      send(2'd0, i, INST, 1, 500 - ((i * 13) % 97), 1, i == DEPTH - 1, "R5 refill");
    for (int i = DEPTH - 1; i >= 0; i--)
      send(2'd2, i, INST, 1, 0, 0, 1, "R7 drain order B");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule